// File: doc/BRIEF.md
# CAN Low-Power Stop and Edge-Wake Sequencer

This block sequences a CAN protocol controller into and out of its low-power stop state. Software writes a stop bit and a self-wake enable through a single write strobe. After a stop request the sequencer waits for a point where the bus is idle. It then gates the protocol core's clock enable and raises a stop acknowledge. If a halt was active when the request arrived, the sequencer first resynchronises to the bus by counting eleven consecutive recessive bit samples.

The receive line is sampled once per bit time, using a bit-sample strobe supplied from outside. The edge detector runs on the ungated clock, so it keeps working while the core is stopped. When self-wake is armed, a recessive-to-dominant edge clears the stop bit in hardware and restarts the core. The same edge raises a one-cycle hint that the dominant bit is a start-of-frame, so the core receives that frame without arbitrating. A wake interrupt is raised only if its mask is set.

The bus-off recovery counter is held at its value while the core is stopped, and it carries on from that value after the core resumes.

Top module: `can_stop_seq`

## Requirements
- R1: When the self-wake enable is set and the stop bit is set, a bit sample with `rx_i`=0 whose previous sample was 1 (1 = recessive) clears `stop_o` at the next clock edge. The core clock enable returns one cycle after that. When self-wake is clear, such an edge has no effect on `stop_o` or `stop_ack_o`.
- R2: Every self-wake event raises `rx_only_start_o` for exactly one cycle, in the cycle in which `stop_o` first reads 0.
- R3: `stop_ack_o` rises only when the stopped state is reached. In that same cycle `core_clk_en_o` falls and `not_rdy_o` is high.
- R4: Writing stop=0 and self-wake=0 together while stopped clears `stop_o` at the write edge. One cycle later `stop_ack_o` falls and `core_clk_en_o` rises.
- R5: A self-wake edge that arrives after a stop request with self-wake, but before the stopped state is reached, clears `stop_o`. In that case `stop_ack_o` is never asserted.
- R6: A stop request made while `halt_i`=1 ignores `core_idle_i`. The block reaches the stopped state only after 11 consecutive recessive samples, counted from the request.
- R7: While `busoff_i`=1, `busoff_cnt_o` counts recessive bit samples only while the core clock is enabled. It holds its value while stopped, continues from that value after exit, and clears when `busoff_outside` goes low, i.e. when `busoff_i`=0.
- R8: `wake_int_o` pulses together with `rx_only_start_o` only when `wake_mask_i`=1. With the mask at 0 it stays low.
- R9: A write that tries to set self-wake is ignored while `stop_o`=1 or `not_rdy_o`=1. A write with self-wake=0 always clears it.
- R10: Without halt, a pending stop request is granted when `core_idle_i`=1 or when the last 11 samples were recessive. Fewer than 11 recessive samples with the core not idle do not stop the core.
- R11: The recessive-run counter resets to 0 on any dominant sample and saturates at 11. A dominant sample inside a run therefore restarts the count of 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Ungated system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_stop_i | input | 1 | Stop request value written |
| cfg_self_wake_i | input | 1 | Self-wake enable value written |
| wake_mask_i | input | 1 | Wake interrupt enable |
| halt_i | input | 1 | Halt mode active |
| busoff_i | input | 1 | Controller is bus-off |
| core_idle_i | input | 1 | Protocol core reports bus idle |
| bit_strobe_i | input | 1 | One-cycle bit-sample strobe |
| rx_i | input | 1 | Receive line, 1 = recessive |
| stop_o | output | 1 | Current stop bit |
| self_wake_o | output | 1 | Current self-wake enable |
| stop_ack_o | output | 1 | Stopped state reached |
| not_rdy_o | output | 1 | Not in normal operation |
| core_clk_en_o | output | 1 | Clock enable for protocol core |
| wake_int_o | output | 1 | Wake interrupt pulse |
| rx_only_start_o | output | 1 | Receive wake frame without arbitration |
| busoff_cnt_o | output | 11 | Bus-off recovery count |

## Verification
Stop entry is swept over recessive runs of 0 to 11 samples after a dominant sample. The sweep separates a stop granted at the eleventh sample from one granted early or never, and a dominant sample placed inside a run shows that the count restarts. The wake edge is applied in three situations: in the stopped state with the mask on and with the mask off, before the acknowledge has been given, and with self-wake clear. These tell a hardware wake apart from an early cancel and from an edge that must be ignored. A request made during halt, with the core reporting idle, shows whether the idle report is wrongly accepted before resynchronisation. Bus-off counts are compared before, during and after a stop.

// File: rtl/can_stop_pkg.sv
package can_stop_pkg;
  localparam int unsigned RESYNC_BITS = 11;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_RESYNC = 2'd1,
    ST_SEEK   = 2'd2,
    ST_STOP   = 2'd3
  } stop_state_e;
endpackage

// File: rtl/can_rec_ctr.sv
module can_rec_ctr #(
  parameter int unsigned MAX = 11,
  localparam int unsigned W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic         rx_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (strobe_i) begin
      if (!rx_i)                  cnt_q <= '0;
      else if (cnt_q != W'(MAX))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == W'(MAX));

  // R11
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(MAX));
  // R11
  dom_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !rx_i) |=> (cnt_q == '0));
endmodule

// File: rtl/can_wake_edge.sv
module can_wake_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic rx_i,
  output logic fall_o
);
  logic prev_q;

  // Runs on the ungated clock so it stays live while stopped.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= 1'b1;
    else if (strobe_i) prev_q <= rx_i;
  end

  assign fall_o = strobe_i & prev_q & ~rx_i;

  // R1
  fall_prev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !prev_q);
endmodule

// File: rtl/can_busoff_ctr.sv
module can_busoff_ctr #(
  parameter int unsigned LIMIT = 1408,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         busoff_i,
  input  logic         run_i,
  input  logic         strobe_i,
  input  logic         rx_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (!busoff_i)                           cnt_q <= '0;
    else if (run_i && strobe_i && rx_i && cnt_q != W'(LIMIT))
                                                  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R7
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busoff_i && !run_i) |=> (!busoff_i || cnt_q == $past(cnt_q)));
  // R7
  limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(LIMIT));
endmodule

// File: rtl/can_stop_seq.sv
module can_stop_seq
  import can_stop_pkg::*;
#(
  parameter int unsigned REC_BITS     = RESYNC_BITS,
  parameter int unsigned BUSOFF_LIMIT = 1408,
  localparam int unsigned RW = $clog2(REC_BITS + 1),
  localparam int unsigned BW = $clog2(BUSOFF_LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_stop_i,
  input  logic          cfg_self_wake_i,
  input  logic          wake_mask_i,
  input  logic          halt_i,
  input  logic          busoff_i,
  input  logic          core_idle_i,
  input  logic          bit_strobe_i,
  input  logic          rx_i,
  output logic          stop_o,
  output logic          self_wake_o,
  output logic          stop_ack_o,
  output logic          not_rdy_o,
  output logic          core_clk_en_o,
  output logic          wake_int_o,
  output logic          rx_only_start_o,
  output logic [BW-1:0] busoff_cnt_o
);
  stop_state_e state_q, state_d;
  logic          stop_q, self_wake_q, wake_evt_q;
  logic          rx_fall, wake_hit, rec_full, rec_clr;
  logic [RW-1:0] rec_cnt;

  can_wake_edge i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(bit_strobe_i),
    .rx_i    (rx_i),
    .fall_o  (rx_fall)
  );

  can_rec_ctr #(.MAX(REC_BITS)) i_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(bit_strobe_i),
    .rx_i    (rx_i),
    .clr_i   (rec_clr),
    .cnt_o   (rec_cnt),
    .full_o  (rec_full)
  );

  can_busoff_ctr #(.LIMIT(BUSOFF_LIMIT)) i_busoff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busoff_i(busoff_i),
    .run_i   (core_clk_en_o),
    .strobe_i(bit_strobe_i),
    .rx_i    (rx_i),
    .cnt_o   (busoff_cnt_o)
  );

  assign wake_hit = stop_q & self_wake_q & rx_fall;
  assign rec_clr  = (state_q == ST_RUN) & stop_q & halt_i;

  assign not_rdy_o       = (state_q != ST_RUN) | halt_i;
  assign core_clk_en_o   = (state_q != ST_STOP);
  assign stop_ack_o      = (state_q == ST_STOP);
  assign stop_o          = stop_q;
  assign self_wake_o     = self_wake_q;
  assign rx_only_start_o = wake_evt_q;
  assign wake_int_o      = wake_evt_q & wake_mask_i;

  // Hardware wake wins over a same-cycle software write.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q      <= 1'b0;
      self_wake_q <= 1'b0;
      wake_evt_q  <= 1'b0;
    end else begin
      wake_evt_q <= wake_hit;
      if (wake_hit)      stop_q <= 1'b0;
      else if (cfg_we_i) stop_q <= cfg_stop_i;
      if (cfg_we_i) begin
        if (!cfg_self_wake_i)             self_wake_q <= 1'b0;
        else if (!stop_q && !not_rdy_o)   self_wake_q <= 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (stop_q) state_d = halt_i ? ST_RESYNC : ST_SEEK;
      ST_RESYNC: if (!stop_q) state_d = ST_RUN;
                 else if (rec_full) state_d = ST_SEEK;
      ST_SEEK:   if (!stop_q) state_d = ST_RUN;
                 else if (!wake_hit && (core_idle_i || rec_full)) state_d = ST_STOP;
      ST_STOP:   if (!stop_q) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  // R3
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_ack_o) |-> $past(core_idle_i || rec_full));
  // R1
  wake_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_hit |=> !stop_o);
  // R5
  early_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_ack_o && wake_hit) |=> !stop_ack_o);
  // R9
  sw_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (stop_q || not_rdy_o) && !self_wake_q) |=> !self_wake_o);
  // R4
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ack_o && !stop_q) |=> core_clk_en_o);
  // R8
  wake_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_int_o |-> ($past(stop_q) && !stop_q));
endmodule

// File: tb/test_can_stop_seq.sv
module test_can_stop_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 0, c_stop = 0, c_sw = 0, mask = 0, halt = 0, busoff = 0, idle = 0;
  logic strobe = 0, rx = 1'b1;
  logic stop_o, sw_o, ack, nrdy, clk_en, wint, rxo;
  logic [10:0] bcnt;
  int checks = 0, errors = 0;
  logic mon_en = 0, ack_seen = 0;

  always #10 clk = ~clk;

  can_stop_seq i_can_stop_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_stop_i(c_stop),
    .cfg_self_wake_i(c_sw), .wake_mask_i(mask), .halt_i(halt), .busoff_i(busoff),
    .core_idle_i(idle), .bit_strobe_i(strobe), .rx_i(rx), .stop_o(stop_o),
    .self_wake_o(sw_o), .stop_ack_o(ack), .not_rdy_o(nrdy), .core_clk_en_o(clk_en),
    .wake_int_o(wint), .rx_only_start_o(rxo), .busoff_cnt_o(bcnt)
  );

  always @(negedge clk) if (mon_en && ack) ack_seen <= 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic w);
    we = 1; c_stop = s; c_sw = w;
    @(negedge clk);
    we = 0;
  endtask

  task automatic bitx(input logic v);
    rx = v; strobe = 1;
    @(negedge clk);
    strobe = 0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(1);
    // reset state
    chk("R3 reset ack", ack, 0);
    chk("R3 reset clk_en", clk_en, 1);
    chk("R9 reset nrdy", nrdy, 0);
    chk("R8 reset wint", wint, 0);

    // R9: self-wake set ignored while stop is set
    bitx(0);
    wr(1, 0);
    wr(1, 1);
    cyc(1);
    chk("R9 sw while stop", sw_o, 0);
    wr(0, 0);
    cyc(2);
    halt = 1;
    cyc(1);
    chk("R9 nrdy in halt", nrdy, 1);
    wr(0, 1);
    chk("R9 sw while not ready", sw_o, 0);
    halt = 0;
    cyc(1);

    // R10 / R11: sweep recessive run length
    for (int n = 0; n <= 11; n++) begin
      bitx(0);
      wr(1, 0);
      for (int k = 0; k < n; k++) bitx(1);
      cyc(2);
      chk($sformatf("R10 run %0d ack", n), ack, (n >= 11) ? 1 : 0);
      wr(0, 0);
      cyc(2);
    end
    // R11: dominant sample restarts count
    bitx(0);
    wr(1, 0);
    for (int k = 0; k < 6; k++) bitx(1);
    bitx(0);
    for (int k = 0; k < 10; k++) bitx(1);
    cyc(2);
    chk("R11 restart 10", ack, 0);
    bitx(1);
    cyc(2);
    chk("R11 restart 11", ack, 1);
    chk("R3 clk_en low", clk_en, 0);
    chk("R3 nrdy high", nrdy, 1);
    // R1 negative: edge without self-wake
    bitx(1);
    bitx(0);
    cyc(2);
    chk("R1 no sw stop", stop_o, 1);
    chk("R1 no sw ack", ack, 1);
    wr(0, 0);
    cyc(2);

    // R1/R2/R8: wake from stopped, both mask values
    for (int m = 1; m >= 0; m--) begin
      mask = logic'(m);
      idle = 1;
      wr(1, 1);
      cyc(3);
      idle = 0;
      chk("R3 stopped", ack, 1);
      bitx(1);
      chk("R1 recessive no wake", stop_o, 1);
      bitx(0);
      chk("R1 stop cleared", stop_o, 0);
      chk("R2 rx only", rxo, 1);
      chk("R8 wake int", wint, m);
      chk("R4 ack still", ack, 1);
      cyc(1);
      chk("R1 clk back", clk_en, 1);
      chk("R1 ack low", ack, 0);
      chk("R2 one cycle", rxo, 0);
      wr(0, 0);
      cyc(1);
    end

    // R4: software exit
    idle = 1;
    wr(1, 1);
    cyc(3);
    idle = 0;
    chk("R4 entered", ack, 1);
    wr(0, 0);
    chk("R4 stop bit", stop_o, 0);
    chk("R4 ack holds one cycle", ack, 1);
    cyc(1);
    chk("R4 ack fall", ack, 0);
    chk("R4 clk_en rise", clk_en, 1);

    // R5: early cancel
    bitx(0);
    ack_seen = 0;
    mon_en = 1;
    wr(1, 1);
    bitx(1);
    bitx(0);
    cyc(5);
    mon_en = 0;
    chk("R5 stop cleared", stop_o, 0);
    chk("R5 no ack", ack_seen, 0);
    chk("R5 rx only", rxo, 0);
    wr(0, 0);
    cyc(2);

    // R6: halt resync ignores idle
    halt = 1;
    idle = 1;
    wr(1, 0);
    cyc(3);
    chk("R6 idle ignored", ack, 0);
    for (int k = 0; k < 10; k++) bitx(1);
    cyc(2);
    chk("R6 ten bits", ack, 0);
    bitx(1);
    cyc(2);
    chk("R6 eleven bits", ack, 1);
    halt = 0;
    idle = 0;
    wr(0, 0);
    cyc(2);

    // R7: bus-off counter freeze
    busoff = 1;
    for (int k = 0; k < 5; k++) bitx(1);
    chk("R7 count run", bcnt, 5);
    idle = 1;
    wr(1, 0);
    cyc(2);
    idle = 0;
    chk("R7 stopped", ack, 1);
    for (int k = 0; k < 7; k++) bitx(1);
    chk("R7 frozen", bcnt, 5);
    wr(0, 0);
    cyc(1);
    for (int k = 0; k < 3; k++) bitx(1);
    chk("R7 resumed", bcnt, 8);
    busoff = 0;
    cyc(1);
    chk("R7 cleared", bcnt, 0);

    finish_run();
  end
endmodule